// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the frequency-offset profile that a spread-spectrum clock synthesizer follows. On every cycle of the input clock it presents a signed offset word in units of 0.001 %. A downstream fractional divider or oscillator control word applies that offset to the output frequency. The profile is a symmetric triangle with a period of 1000 input cycles. The total deviation is either 1.25 % or 3.75 %. The deviation either lies entirely below the nominal frequency (down placement) or is split evenly around it (center placement).

A small state machine walks a phase counter through the profile. It has three states:
- **PS_IDLE**: spreading is off and the offset is zero.
- **PS_RISE**: the phase counts up from 0 to 499.
- **PS_FALL**: the phase counts down from 500 to 1.

The state machine has these transitions:
- **start**: PS_IDLE to PS_RISE, when the active-low enable is seen low.
- **turn**: PS_RISE to PS_FALL, at phase 499.
- **wrap**: PS_FALL to PS_RISE, at phase 1. This is the period boundary.
- **restart**: PS_RISE or PS_FALL to PS_RISE at phase 0, on a synchronized restart edge.
- **stop**: any state to PS_IDLE, when the enable is seen high.

Width and placement selects are captured only on start, wrap and restart, so a change never causes a jump in the middle of a period. The block also gives the synthesizer three more outputs:
- a registered copy of the 2-bit range select;
- a registered output-disable flag taken from an active-low output enable;
- a reference offset word that is always zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `spread_en_n_i` is sampled high at a clock edge, `offset_o` is 0 after that edge and the state is PS_IDLE with phase 0.
- R2: After an edge that samples `spread_en_n_i` low in PS_IDLE, the phase is 0 in PS_RISE. The phase then steps +1 per cycle up to 499, goes to 500 in PS_FALL, steps −1 down to 1, and wraps to 0 in PS_RISE. The period is 1000 cycles.
- R3: The width select `width_sel_i` = 0 gives a span W of 1250 (1.25 %). A value of 1 gives a span W of 3750 (3.75 %).
- R4: For phase p, the magnitude is m = floor(p·W/500). With `center_mode_i` = 0 (down placement), `offset_o` = −m. With `center_mode_i` = 1 (center placement), `offset_o` = m − W/2, so it sweeps ±625 or ±1875.
- R5: Width and placement are captured only on the start, wrap and restart transitions. A change at any other time leaves `offset_o` on the old profile until the next such transition.
- R6: When `restart_i` is sampled 0 at edge k−1 and 1 at edge k, and spreading stays enabled, the edge k+2 puts the profile at phase 0 in PS_RISE. A restart edge is ignored while spreading is disabled.
- R7: `out_hiz_o` equals `oe_n_i` as sampled at the previous clock edge, so 1 means the outputs are disabled.
- R8: `range_o` equals `range_sel_i` as sampled at the previous clock edge. The range select has no effect on `offset_o`.
- R9: `ref_offset_o` is always 0, whatever the enable, restart or select inputs do.
- R10: During reset, `offset_o` is 0, `range_o` is 0 and `out_hiz_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (reference) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en_n_i | input | 1 | Spread enable, active low |
| width_sel_i | input | 1 | 0: 1.25 % span, 1: 3.75 % span |
| center_mode_i | input | 1 | 0: down placement, 1: center placement |
| restart_i | input | 1 | Asynchronous restart; its rising edge restarts the profile |
| range_sel_i | input | 2 | Frequency range select for the synthesizer |
| oe_n_i | input | 1 | Output enable, active low |
| offset_o | output | 16 | Signed offset in 0.001 % units |
| ref_offset_o | output | 16 | Offset for the unmodulated reference path (always 0) |
| range_o | output | 2 | Registered range select |
| out_hiz_o | output | 1 | Registered output-disable flag |

## Verification
The bench targets the turn points of the triangle (phase 499 to 500 and phase 1 to 0). A design that is off by one there stretches the period, or repeats a peak value, and drifts from the reference model within a cycle. Select changes in the middle of a period catch a design that applies them at once, which shows as a step in the offset. Restart pulses one cycle long, including one sent while spreading is off, check the two-edge latency and that a disabled block ignores the pulse. Measuring the minimum and maximum over a full period in all four width and placement combinations catches a wrong span, a wrong sign or a missing half-span shift.

// File: rtl/ssc_prof_pkg.sv
package ssc_prof_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_RISE = 2'd1,
        PS_FALL = 2'd2
    } prof_state_e;

endpackage

// File: rtl/ssc_restart_edge.sv
// Synchronizes an asynchronous restart request and emits a one-cycle
// pulse on its rising edge.
module ssc_restart_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign pulse_o = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/ssc_phase_fsm.sv
// Triangle phase sequencer: ramps 0..HALF_STEPS-1 up, HALF_STEPS..1 down.
module ssc_phase_fsm
    import ssc_prof_pkg::*;
#(
    parameter int HALF_STEPS = 500,
    parameter int PH_W       = $clog2(HALF_STEPS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            restart_i,
    input  logic            width_sel_i,
    input  logic            center_mode_i,
    output prof_state_e     state_o,
    output logic [PH_W-1:0] phase_o,
    output logic            active_o,
    output logic            wide_o,
    output logic            center_o
);
    localparam logic [PH_W-1:0] LAST_UP  = PH_W'(HALF_STEPS - 1);
    localparam logic [PH_W-1:0] PEAK     = PH_W'(HALF_STEPS);
    localparam logic [PH_W-1:0] LAST_DN  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_ONE   = PH_W'(1);

    prof_state_e     st_q, st_d;
    logic [PH_W-1:0] ph_q, ph_d;
    logic            wide_q, wide_d;
    logic            cen_q, cen_d;
    logic            latch_cfg;

    // next-state and phase logic
    always_comb begin
        st_d      = st_q;
        ph_d      = ph_q;
        latch_cfg = 1'b0;
        if (!en_i) begin
            st_d = PS_IDLE;                    // stop
            ph_d = '0;
        end else if (restart_i) begin
            st_d      = PS_RISE;               // restart
            ph_d      = '0;
            latch_cfg = 1'b1;
        end else begin
            unique case (st_q)
                PS_IDLE: begin
                    st_d      = PS_RISE;       // start
                    ph_d      = '0;
                    latch_cfg = 1'b1;
                end
                PS_RISE: begin
                    if (ph_q == LAST_UP) begin
                        st_d = PS_FALL;        // turn
                        ph_d = PEAK;
                    end else begin
                        ph_d = ph_q + PH_ONE;
                    end
                end
                PS_FALL: begin
                    if (ph_q == LAST_DN) begin
                        st_d      = PS_RISE;   // wrap
                        ph_d      = '0;
                        latch_cfg = 1'b1;
                    end else begin
                        ph_d = ph_q - PH_ONE;
                    end
                end
                default: begin
                    st_d = PS_IDLE;
                    ph_d = '0;
                end
            endcase
        end
        wide_d = latch_cfg ? width_sel_i   : wide_q;
        cen_d  = latch_cfg ? center_mode_i : cen_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_IDLE;
            ph_q   <= '0;
            wide_q <= 1'b0;
            cen_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            wide_q <= wide_d;
            cen_q  <= cen_d;
        end
    end

    // outputs
    always_comb begin
        state_o  = st_q;
        phase_o  = ph_q;
        active_o = (st_q != PS_IDLE);
        wide_o   = wide_q;
        center_o = cen_q;
    end

endmodule

// File: rtl/ssc_offset_scale.sv
// Maps a triangle phase onto a signed offset in 0.001 % units.
module ssc_offset_scale #(
    parameter int HALF_STEPS = 500,
    parameter int SPAN_LO    = 1250,
    parameter int SPAN_HI    = 3750,
    parameter int OFF_W      = 16,
    parameter int PH_W       = $clog2(HALF_STEPS + 1)
) (
    input  logic                    active_i,
    input  logic [PH_W-1:0]         phase_i,
    input  logic                    wide_i,
    input  logic                    center_i,
    output logic signed [OFF_W-1:0] offset_o
);
    localparam int SPAN_W = $clog2(SPAN_HI + 1);
    localparam int PROD_W = PH_W + SPAN_W;

    logic [SPAN_W-1:0] span;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] mag;
    logic [OFF_W-1:0]  mag_t;
    logic [OFF_W-1:0]  half_t;

    always_comb begin
        span   = wide_i ? SPAN_W'(SPAN_HI) : SPAN_W'(SPAN_LO);
        prod   = PROD_W'(phase_i) * PROD_W'(span);
        mag    = prod / PROD_W'(HALF_STEPS);
        mag_t  = OFF_W'(mag);
        half_t = OFF_W'(span >> 1);
        if (!active_i)     offset_o = '0;
        else if (center_i) offset_o = $signed(mag_t - half_t);
        else               offset_o = $signed(-mag_t);
    end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_prof_pkg::*;
#(
    parameter int HALF_STEPS  = 500,
    parameter int SPAN_LO     = 1250,
    parameter int SPAN_HI     = 3750,
    parameter int OFF_W       = 16,
    parameter int RANGE_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en_n_i,
    input  logic                    width_sel_i,
    input  logic                    center_mode_i,
    input  logic                    restart_i,
    input  logic [RANGE_W-1:0]      range_sel_i,
    input  logic                    oe_n_i,
    output logic signed [OFF_W-1:0] offset_o,
    output logic signed [OFF_W-1:0] ref_offset_o,
    output logic [RANGE_W-1:0]      range_o,
    output logic                    out_hiz_o
);
    localparam int PH_W = $clog2(HALF_STEPS + 1);

    logic            restart_pulse;
    prof_state_e     prof_state;
    logic [PH_W-1:0] prof_phase;
    logic            prof_active;
    logic            prof_wide;
    logic            prof_center;

    ssc_restart_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (restart_i),
        .pulse_o (restart_pulse)
    );

    ssc_phase_fsm #(.HALF_STEPS(HALF_STEPS), .PH_W(PH_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (~spread_en_n_i),
        .restart_i     (restart_pulse),
        .width_sel_i   (width_sel_i),
        .center_mode_i (center_mode_i),
        .state_o       (prof_state),
        .phase_o       (prof_phase),
        .active_o      (prof_active),
        .wide_o        (prof_wide),
        .center_o      (prof_center)
    );

    ssc_offset_scale #(
        .HALF_STEPS (HALF_STEPS),
        .SPAN_LO    (SPAN_LO),
        .SPAN_HI    (SPAN_HI),
        .OFF_W      (OFF_W),
        .PH_W       (PH_W)
    ) u_scale (
        .active_i (prof_active),
        .phase_i  (prof_phase),
        .wide_i   (prof_wide),
        .center_i (prof_center),
        .offset_o (offset_o)
    );

    // side-band registers handed to the synthesizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            range_o   <= '0;
            out_hiz_o <= 1'b1;
        end else begin
            range_o   <= range_sel_i;
            out_hiz_o <= oe_n_i;
        end
    end

    assign ref_offset_o = '0;

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
    import ssc_prof_pkg::*;
#(
    parameter int HALF_STEPS = 500,
    parameter int SPAN_HI    = 3750,
    parameter int OFF_W      = 16,
    parameter int RANGE_W    = 2,
    parameter int PH_W       = $clog2(HALF_STEPS + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    spread_en_n_i,
    input logic                    oe_n_i,
    input logic [RANGE_W-1:0]      range_sel_i,
    input logic signed [OFF_W-1:0] offset_o,
    input logic [RANGE_W-1:0]      range_o,
    input logic                    out_hiz_o,
    input logic                    restart_pulse,
    input prof_state_e             prof_state,
    input logic [PH_W-1:0]         prof_phase
);
    p_disabled_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spread_en_n_i |=> (offset_o == '0 && prof_state == PS_IDLE));

    p_rise_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spread_en_n_i && !restart_pulse && prof_state == PS_RISE &&
         prof_phase != PH_W'(HALF_STEPS - 1))
        |=> (prof_phase == $past(prof_phase) + PH_W'(1)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spread_en_n_i && !restart_pulse && prof_state == PS_FALL &&
         prof_phase == PH_W'(1))
        |=> (prof_state == PS_RISE && prof_phase == '0));

    p_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o >= -(OFF_W'(SPAN_HI))) && (offset_o <= OFF_W'(SPAN_HI / 2)));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!spread_en_n_i && restart_pulse)
        |=> (prof_state == PS_RISE && prof_phase == '0));

    p_hiz_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |=> out_hiz_o);

    p_hiz_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_i |=> !out_hiz_o);

    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (range_o == $past(range_sel_i)));

endmodule

bind ssc_profile_gen ssc_profile_chk #(
    .HALF_STEPS (HALF_STEPS),
    .SPAN_HI    (SPAN_HI),
    .OFF_W      (OFF_W),
    .RANGE_W    (RANGE_W),
    .PH_W       (PH_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .spread_en_n_i (spread_en_n_i),
    .oe_n_i        (oe_n_i),
    .range_sel_i   (range_sel_i),
    .offset_o      (offset_o),
    .range_o       (range_o),
    .out_hiz_o     (out_hiz_o),
    .restart_pulse (restart_pulse),
    .prof_state    (prof_state),
    .prof_phase    (prof_phase)
);

// File: tb/tb_ssc_profile_gen.sv
`timescale 1ns/1ps
module tb_ssc_profile_gen;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spread_en_n_i = 1'b1;
    logic              width_sel_i = 1'b0;
    logic              center_mode_i = 1'b0;
    logic              restart_i = 1'b0;
    logic [1:0]        range_sel_i = 2'd0;
    logic              oe_n_i = 1'b1;
    logic signed [15:0] offset_o;
    logic signed [15:0] ref_offset_o;
    logic [1:0]        range_o;
    logic              out_hiz_o;

    always #2 clk = ~clk;   // 250 MHz

    ssc_profile_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .spread_en_n_i (spread_en_n_i),
        .width_sel_i   (width_sel_i),
        .center_mode_i (center_mode_i),
        .restart_i     (restart_i),
        .range_sel_i   (range_sel_i),
        .oe_n_i        (oe_n_i),
        .offset_o      (offset_o),
        .ref_offset_o  (ref_offset_o),
        .range_o       (range_o),
        .out_hiz_o     (out_hiz_o)
    );

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R10";

    // behavioural reference model
    bit m_active;
    bit m_up;
    int m_phase;
    bit m_wide, m_center;
    int m_range;
    bit m_hiz;
    bit rs_q[$];        // restart samples, newest first

    function automatic int exp_offset();
        int w, m;
        if (!m_active) return 0;
        w = m_wide ? 3750 : 1250;
        m = (m_phase * w) / 500;
        return m_center ? (m - w / 2) : -m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_up = 1; m_phase = 0; m_wide = 0; m_center = 0;
            m_range = 0; m_hiz = 1;
            rs_q = '{0, 0, 0};
        end else begin
            bit eff;
            eff = rs_q[1] && !rs_q[2];
            rs_q.push_front(restart_i);
            void'(rs_q.pop_back());
            if (spread_en_n_i) begin
                m_active = 0; m_up = 1; m_phase = 0;
            end else if (!m_active || eff) begin
                m_active = 1; m_up = 1; m_phase = 0;
                m_wide = width_sel_i; m_center = center_mode_i;
            end else if (m_up) begin
                if (m_phase == 499) begin m_phase = 500; m_up = 0; end
                else m_phase++;
            end else begin
                if (m_phase == 1) begin
                    m_phase = 0; m_up = 1;
                    m_wide = width_sel_i; m_center = center_mode_i;
                end else m_phase--;
            end
            m_range = int'(range_sel_i);
            m_hiz = oe_n_i;
        end
    end

    task automatic check_val(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    bit track = 0;
    int seen_min, seen_max;

    task automatic compare();
        check_val(cur_req, "offset", int'(offset_o), exp_offset());
        check_val("R9", "ref_offset", int'(ref_offset_o), 0);
        check_val("R8", "range", int'(range_o), m_range);
        check_val("R7", "out_hiz", int'(out_hiz_o), int'(m_hiz));
        if (track) begin
            if (int'(offset_o) < seen_min) seen_min = int'(offset_o);
            if (int'(offset_o) > seen_max) seen_max = int'(offset_o);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    // R3/R4: full period extremes for one width/placement setting
    task automatic span_test(bit wide, bit cen, int exp_min, int exp_max, string req);
        spread_en_n_i = 1'b1;
        step(2);
        width_sel_i = wide; center_mode_i = cen;
        spread_en_n_i = 1'b0;
        step(1);
        seen_min = 100000; seen_max = -100000; track = 1;
        step(1000);
        track = 0;
        check_val(req, "period min", seen_min, exp_min);
        check_val(req, "period max", seen_max, exp_max);
    endtask

    bit done = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R10: reset values
        step(3);
        check_val("R10", "reset offset", int'(offset_o), 0);
        check_val("R10", "reset range", int'(range_o), 0);
        check_val("R10", "reset hiz", int'(out_hiz_o), 1);
        rst_n = 1'b1;

        // R1: disabled, other inputs toggling, restart ignored (R6)
        cur_req = "R1";
        width_sel_i = 1; center_mode_i = 1; range_sel_i = 2'd3; oe_n_i = 0;
        step(3);
        restart_i = 1; step(1); restart_i = 0;
        step(5);

        // R2: enable and follow the whole triangle, past a wrap
        cur_req = "R2";
        width_sel_i = 0; center_mode_i = 0;
        spread_en_n_i = 0;
        step(2100);

        // R3 and R4: extremes of all four settings
        cur_req = "R4";
        span_test(0, 0, -1250, 0,    "R3");
        span_test(1, 0, -3750, 0,    "R3");
        span_test(0, 1, -625,  625,  "R4");
        span_test(1, 1, -1875, 1875, "R4");

        // R5: select changes mid-period apply only after the wrap
        cur_req = "R5";
        step(137);
        width_sel_i = 0; center_mode_i = 0;
        step(300);
        width_sel_i = 1;
        step(1200);

        // R6: one-cycle restart pulses in both ramps
        cur_req = "R6";
        restart_i = 1; step(1); restart_i = 0;
        step(250);
        restart_i = 1; step(1); restart_i = 0;
        step(700);
        restart_i = 1; step(4); restart_i = 0;
        step(20);

        // R8/R7: range and output enable churn, offset unaffected
        cur_req = "R8";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            range_sel_i = lfsr[1:0];
            oe_n_i = lfsr[5];
            step(1);
        end

        // R1: disable mid-ramp, re-enable later
        cur_req = "R1";
        spread_en_n_i = 1;
        step(10);
        check_val("R1", "disabled offset", int'(offset_o), 0);
        cur_req = "R2";
        spread_en_n_i = 0;
        step(30);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule